// File: doc/BRIEF.md
# Activity Monitor Counter Bank

This block keeps a per-core set of 64-bit activity counters for system-management software. Four fixed counters track core clock cycles, constant-rate reference ticks, retired instructions and cycles lost to last-level-cache miss stalls. A configurable group of auxiliary counters, with one event strobe each, sits beside them. Each counter has its own enable. No counter moves while the core reports a low-power wait state.

Software reaches the counters through a single-cycle register port. The port has a group select, a 4-bit index, a write strobe and a 2-bit privilege tag. Reads are combinational and return the value the counter holds before the current clock edge. A write loads all 64 bits at the next edge, so a counter can be saved and restored around a power-off. Accesses tagged with the lowest privilege level are refused unless a user-access enable is high. A refused access sets a fault flag, returns zero and changes nothing.

Top module: `activity_counter_bank`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every fixed and auxiliary counter to zero.
- R2: Fixed slot 0 (core cycles) increases by one on every clock edge where it is enabled and wait_i is low.
- R3: Fixed slot 1 (reference ticks) increases by one on each edge where ref_tick_i is high, it is enabled and wait_i is low.
- R4: Fixed slot 2 (retired instructions) adds the value of retire_cnt_i (0 to 3) on each edge where it is enabled and wait_i is low.
- R5: Fixed slot 3 increases by one per enabled non-waiting edge with stall_ev_i high. Auxiliary counter n increases by one per enabled non-waiting edge with aux_ev_i[n] high.
- R6: While wait_i is high, no counter changes value except through a register write.
- R7: A counter whose enable is low reads as zero and keeps its stored value. When it is enabled again, it shows the value it held before it was disabled.
- R8: acc_group_i selects the group: 0 for fixed, 1 for auxiliary. Fixed indices 0 to 3 and auxiliary indices below NUM_AUX are implemented. Any other index reads as zero, and a write to it changes no counter.
- R9: An access with acc_priv_i equal to 0 while user_acc_en_i is low sets fault_o, returns zero read data and leaves every counter unchanged. Any other privilege value, or a high user_acc_en_i, gives no fault.
- R10: A granted write loads the full 64-bit acc_wdata_i at the next edge and takes priority over any increment on that same edge. A write is accepted whether the target counter is enabled or not.
- R11: A counter wraps from all ones to zero with no flag raised.
- R12: rd_data_o is combinational. It shows the counter's value from before the current edge's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_i | input | 1 | Core is in a low-power wait state; freezes counting |
| ref_tick_i | input | 1 | Constant-rate reference tick, already in the core clock domain |
| retire_cnt_i | input | RET_W | Instructions retired this cycle |
| stall_ev_i | input | 1 | Dispatch stall caused by a last-level cache miss this cycle |
| aux_ev_i | input | NUM_AUX | Auxiliary event strobes |
| fix_en_i | input | 4 | Enables for the fixed counters |
| aux_en_i | input | NUM_AUX | Enables for the auxiliary counters |
| user_acc_en_i | input | 1 | Permits accesses at the lowest privilege level |
| acc_valid_i | input | 1 | Register access this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_group_i | input | 1 | 0 = fixed group, 1 = auxiliary group |
| acc_idx_i | input | 4 | Counter index within the group |
| acc_priv_i | input | 2 | Privilege level of the access, 0 = lowest |
| acc_wdata_i | input | 64 | Write data |
| rd_data_o | output | 64 | Read data |
| fault_o | output | 1 | Access refused for privilege |

## Verification
The embedded properties are checked on every cycle. They cover these behaviours: a refused access produces no write strobe and zero data, at most one counter is written per access, a write lands exactly, an idle or waiting counter holds its value, a running counter advances by its increment modulo 2^64, and reset clears every counter. Some behaviours can only be shown by the bench's scenarios. These are the accumulated totals under mixed event patterns, the hiding of a disabled counter's value and its later recovery, the handling of unimplemented indices, the wrap seen at the read port, and the ordering of a read against the same-edge increment. The bench covers them with an event sweep, an exhaustive sweep over index, privilege and user enable, and targeted write sequences.

// File: rtl/act_mon_pkg.sv
// Shared constants and types for the activity monitor counter bank.
// Assumes a 4-bit index space per group and four implemented fixed slots.
package act_mon_pkg;
    localparam int FIX_NUM = 4;
    localparam int IDX_W   = 4;

    typedef enum logic [1:0] {
        SLOT_CORE  = 2'd0,
        SLOT_REF   = 2'd1,
        SLOT_RET   = 2'd2,
        SLOT_STALL = 2'd3
    } fix_slot_e;

    typedef enum logic {
        GRP_FIXED = 1'b0,
        GRP_AUX   = 1'b1
    } grp_e;

    localparam logic [1:0] PRIV_LOWEST = 2'd0;
endpackage

// File: rtl/act_counter.sv
// One wide event counter. A load has priority over counting. When run_i is
// high the counter adds inc_i, wrapping modulo 2^W. Assumes the load and run
// qualifiers are already decoded by the parent.
module act_counter #(
    parameter int W     = 64,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic             load_i,
    input  logic [W-1:0]     load_val_i,
    output logic [W-1:0]     count_o
);
    logic [W-1:0] count_q;

    // Counter state: reset, software load, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (load_i) count_q <= load_val_i;
        else if (run_i)  count_q <= count_q + W'(inc_i);
    end

    assign count_o = count_q;

    // R10
    load_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(load_val_i));

    // R11
    run_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i) |=> count_o == $past(count_o) + W'($past(inc_i)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/act_access_ctrl.sv
// Register-port decoder. It checks privilege, decodes group and index into
// write strobes, and muxes read data. Disabled or unimplemented slots read
// as zero. Assumes all counter values are presented in parallel.
module act_access_ctrl
    import act_mon_pkg::*;
#(
    parameter int W       = 64,
    parameter int NUM_AUX = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid_i,
    input  logic               acc_write_i,
    input  logic               acc_group_i,
    input  logic [IDX_W-1:0]   acc_idx_i,
    input  logic [1:0]         acc_priv_i,
    input  logic               user_acc_en_i,
    input  logic [FIX_NUM-1:0] fix_en_i,
    input  logic [NUM_AUX-1:0] aux_en_i,
    input  logic [W-1:0]       fix_val_i [FIX_NUM],
    input  logic [W-1:0]       aux_val_i [NUM_AUX],
    output logic [FIX_NUM-1:0] fix_wr_o,
    output logic [NUM_AUX-1:0] aux_wr_o,
    output logic [W-1:0]       rd_data_o,
    output logic               fault_o
);
    logic granted;
    logic fix_sel;
    logic aux_sel;

    // Privilege trap and group qualification.
    always_comb begin
        fault_o = acc_valid_i && (acc_priv_i == PRIV_LOWEST) && !user_acc_en_i;
        granted = acc_valid_i && !fault_o;
        fix_sel = granted && (grp_e'(acc_group_i) == GRP_FIXED);
        aux_sel = granted && (grp_e'(acc_group_i) == GRP_AUX);
    end

    // Index decode into write strobes and read mux.
    always_comb begin
        fix_wr_o  = '0;
        aux_wr_o  = '0;
        rd_data_o = '0;
        for (int i = 0; i < FIX_NUM; i++) begin
            if (fix_sel && acc_idx_i == IDX_W'(i)) begin
                fix_wr_o[i] = acc_write_i;
                if (fix_en_i[i]) rd_data_o = fix_val_i[i];
            end
        end
        for (int j = 0; j < NUM_AUX; j++) begin
            if (aux_sel && acc_idx_i == IDX_W'(j)) begin
                aux_wr_o[j] = acc_write_i;
                if (aux_en_i[j]) rd_data_o = aux_val_i[j];
            end
        end
    end

    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (rd_data_o == '0 && fix_wr_o == '0 && aux_wr_o == '0));

    // R8
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fix_wr_o, aux_wr_o}));

    // R8
    write_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid_i || !acc_write_i) |-> ({fix_wr_o, aux_wr_o} == '0));
endmodule

// File: rtl/activity_counter_bank.sv
// Per-core activity monitor bank: four fixed event counters plus NUM_AUX
// auxiliary counters, with a privileged register port. Counting is gated by
// each enable and frozen while wait_i is high. Assumes event strobes are
// synchronous to clk.
module activity_counter_bank
    import act_mon_pkg::*;
#(
    parameter int W       = 64,
    parameter int NUM_AUX = 4,
    parameter int RET_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wait_i,
    input  logic               ref_tick_i,
    input  logic [RET_W-1:0]   retire_cnt_i,
    input  logic               stall_ev_i,
    input  logic [NUM_AUX-1:0] aux_ev_i,
    input  logic [FIX_NUM-1:0] fix_en_i,
    input  logic [NUM_AUX-1:0] aux_en_i,
    input  logic               user_acc_en_i,
    input  logic               acc_valid_i,
    input  logic               acc_write_i,
    input  logic               acc_group_i,
    input  logic [IDX_W-1:0]   acc_idx_i,
    input  logic [1:0]         acc_priv_i,
    input  logic [W-1:0]       acc_wdata_i,
    output logic [W-1:0]       rd_data_o,
    output logic               fault_o
);
    logic [W-1:0]       fix_cnt [FIX_NUM];
    logic [W-1:0]       aux_cnt [NUM_AUX];
    logic [RET_W-1:0]   fix_inc [FIX_NUM];
    logic [FIX_NUM-1:0] fix_wr;
    logic [NUM_AUX-1:0] aux_wr;

    act_access_ctrl #(.W(W), .NUM_AUX(NUM_AUX)) u_access (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid_i   (acc_valid_i),
        .acc_write_i   (acc_write_i),
        .acc_group_i   (acc_group_i),
        .acc_idx_i     (acc_idx_i),
        .acc_priv_i    (acc_priv_i),
        .user_acc_en_i (user_acc_en_i),
        .fix_en_i      (fix_en_i),
        .aux_en_i      (aux_en_i),
        .fix_val_i     (fix_cnt),
        .aux_val_i     (aux_cnt),
        .fix_wr_o      (fix_wr),
        .aux_wr_o      (aux_wr),
        .rd_data_o     (rd_data_o),
        .fault_o       (fault_o)
    );

    for (genvar g = 0; g < FIX_NUM; g++) begin : g_fix
        // Per-slot increment source, picked by the slot's meaning.
        if (g == int'(SLOT_CORE)) begin : g_core
            assign fix_inc[g] = RET_W'(1);
        end else if (g == int'(SLOT_REF)) begin : g_ref
            assign fix_inc[g] = RET_W'(ref_tick_i);
        end else if (g == int'(SLOT_RET)) begin : g_ret
            assign fix_inc[g] = retire_cnt_i;
        end else begin : g_stall
            assign fix_inc[g] = RET_W'(stall_ev_i);
        end

        act_counter #(.W(W), .INC_W(RET_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (fix_en_i[g] && !wait_i),
            .inc_i      (fix_inc[g]),
            .load_i     (fix_wr[g]),
            .load_val_i (acc_wdata_i),
            .count_o    (fix_cnt[g])
        );

        // R6
        fix_wait_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_i && !fix_wr[g]) |=> $stable(fix_cnt[g]));

        // R1
        fix_reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> fix_cnt[g] == '0);
    end

    for (genvar a = 0; a < NUM_AUX; a++) begin : g_aux
        act_counter #(.W(W), .INC_W(1)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (aux_en_i[a] && !wait_i),
            .inc_i      (aux_ev_i[a]),
            .load_i     (aux_wr[a]),
            .load_val_i (acc_wdata_i),
            .count_o    (aux_cnt[a])
        );

        // R6
        aux_wait_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_i && !aux_wr[a]) |=> $stable(aux_cnt[a]));

        // R1
        aux_reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> aux_cnt[a] == '0);
    end
endmodule

// File: tb/activity_counter_bank_test.sv
module activity_counter_bank_test;
    localparam int NA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wait_i = 1'b1;
    logic          ref_tick_i = 1'b0;
    logic [1:0]    retire_cnt_i = '0;
    logic          stall_ev_i = 1'b0;
    logic [NA-1:0] aux_ev_i = '0;
    logic [3:0]    fix_en_i = '0;
    logic [NA-1:0] aux_en_i = '0;
    logic          user_acc_en_i = 1'b0;
    logic          acc_valid_i = 1'b0;
    logic          acc_write_i = 1'b0;
    logic          acc_group_i = 1'b0;
    logic [3:0]    acc_idx_i = '0;
    logic [1:0]    acc_priv_i = 2'd1;
    logic [63:0]   acc_wdata_i = '0;
    logic [63:0]   rd_data_o;
    logic          fault_o;

    int chk_cnt = 0;
    int fail_cnt = 0;
    logic [63:0] exp_fix [4];
    logic [63:0] exp_aux [NA];

    activity_counter_bank #(.W(64), .NUM_AUX(NA), .RET_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .wait_i(wait_i), .ref_tick_i(ref_tick_i),
        .retire_cnt_i(retire_cnt_i), .stall_ev_i(stall_ev_i), .aux_ev_i(aux_ev_i),
        .fix_en_i(fix_en_i), .aux_en_i(aux_en_i), .user_acc_en_i(user_acc_en_i),
        .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
        .acc_group_i(acc_group_i), .acc_idx_i(acc_idx_i), .acc_priv_i(acc_priv_i),
        .acc_wdata_i(acc_wdata_i), .rd_data_o(rd_data_o), .fault_o(fault_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic g, input logic [3:0] idx, input logic [1:0] pv,
                      output logic [63:0] d, output logic f);
        acc_valid_i = 1'b1; acc_write_i = 1'b0;
        acc_group_i = g; acc_idx_i = idx; acc_priv_i = pv;
        #1;
        d = rd_data_o; f = fault_o;
        acc_valid_i = 1'b0;
        #1;
    endtask

    task automatic wr(input logic g, input logic [3:0] idx, input logic [1:0] pv,
                      input logic [63:0] val);
        acc_valid_i = 1'b1; acc_write_i = 1'b1;
        acc_group_i = g; acc_idx_i = idx; acc_priv_i = pv; acc_wdata_i = val;
        edge_step();
        acc_valid_i = 1'b0; acc_write_i = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #2000000;
        fail_cnt++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
        $finish;
    end

    initial begin : stim
        logic [63:0] d;
        logic        f;
        logic [63:0] v;
        apply_reset();

        // R1: reset state, read with everything enabled but frozen
        fix_en_i = '1; aux_en_i = '1; wait_i = 1'b1;
        for (int i = 0; i < 4; i++) begin rd(1'b0, 4'(i), 2'd1, d, f); check("R1 fixed reset", d, 64'd0); end
        for (int i = 0; i < NA; i++) begin rd(1'b1, 4'(i), 2'd1, d, f); check("R1 aux reset", d, 64'd0); end

        // preload aux2 while disabled, counting off
        fix_en_i = '0; aux_en_i = '0;
        wr(1'b1, 4'd2, 2'd1, 64'h55);
        aux_en_i = 4'b0100; #1;
        rd(1'b1, 4'd2, 2'd1, d, f);
        check("R10 write accepted while disabled", d, 64'h55);
        aux_en_i = '0;

        // event sweep: aux2 disabled throughout
        foreach (exp_fix[i]) exp_fix[i] = 64'd0;
        foreach (exp_aux[i]) exp_aux[i] = 64'd0;
        exp_aux[2] = 64'h55;
        fix_en_i = 4'b1111; aux_en_i = 4'b1011;
        for (int k = 0; k < 60; k++) begin
            wait_i       = (k % 7 == 6);
            ref_tick_i   = (k % 3 == 0);
            retire_cnt_i = 2'(k % 4);
            stall_ev_i   = (k % 5 == 1);
            aux_ev_i     = 4'(k ^ (k >> 2));
            if (!wait_i) begin
                exp_fix[0] += 1;
                exp_fix[1] += 64'(ref_tick_i);
                exp_fix[2] += 64'(retire_cnt_i);
                exp_fix[3] += 64'(stall_ev_i);
                for (int j = 0; j < NA; j++)
                    if (aux_en_i[j] && aux_ev_i[j]) exp_aux[j] += 1;
            end
            edge_step();
        end
        wait_i = 1'b1; ref_tick_i = 0; retire_cnt_i = 0; stall_ev_i = 0; aux_ev_i = '0;

        rd(1'b0, 4'd0, 2'd1, d, f); check("R2 core cycles", d, exp_fix[0]);
        rd(1'b0, 4'd1, 2'd1, d, f); check("R3 reference ticks", d, exp_fix[1]);
        rd(1'b0, 4'd2, 2'd1, d, f); check("R4 retired count", d, exp_fix[2]);
        rd(1'b0, 4'd3, 2'd1, d, f); check("R5 stall cycles", d, exp_fix[3]);
        for (int j = 0; j < NA; j++)
            if (j != 2) begin rd(1'b1, 4'(j), 2'd1, d, f); check("R5 aux events", d, exp_aux[j]); end
        rd(1'b1, 4'd2, 2'd1, d, f); check("R7 disabled reads zero", d, 64'd0);
        aux_en_i = 4'b1111; #1;
        rd(1'b1, 4'd2, 2'd1, d, f); check("R7 disabled kept value", d, 64'h55);

        // R6: waiting with events present changes nothing
        ref_tick_i = 1; retire_cnt_i = 3; stall_ev_i = 1; aux_ev_i = '1;
        repeat (5) edge_step();
        ref_tick_i = 0; retire_cnt_i = 0; stall_ev_i = 0; aux_ev_i = '0;
        for (int i = 0; i < 4; i++) begin rd(1'b0, 4'(i), 2'd1, d, f); check("R6 wait freeze fixed", d, exp_fix[i]); end
        rd(1'b1, 4'd0, 2'd1, d, f); check("R6 wait freeze aux", d, exp_aux[0]);

        // R8/R9: exhaustive over group, index, privilege, user enable
        for (int g = 0; g < 2; g++)
            for (int idx = 0; idx < 16; idx++)
                for (int pv = 0; pv < 4; pv++)
                    for (int ue = 0; ue < 2; ue++) begin
                        logic exp_f;
                        logic [63:0] exp_d;
                        user_acc_en_i = ue[0];
                        exp_f = (pv == 0) && (ue == 0);
                        if (exp_f) exp_d = 64'd0;
                        else if (g == 0) exp_d = (idx < 4) ? exp_fix[idx] : 64'd0;
                        else exp_d = (idx < NA) ? exp_aux[idx] : 64'd0;
                        rd(g[0], 4'(idx), 2'(pv), d, f);
                        check("R9 fault flag", {63'd0, f}, {63'd0, exp_f});
                        check("R8 R9 read data", d, exp_d);
                    end
        user_acc_en_i = 1'b0;

        // R9: trapped write ignored
        wr(1'b0, 4'd1, 2'd0, 64'hDEAD);
        rd(1'b0, 4'd1, 2'd2, d, f); check("R9 trapped write ignored", d, exp_fix[1]);
        // R9: lowest privilege with user enable writes
        user_acc_en_i = 1'b1;
        wr(1'b0, 4'd1, 2'd0, 64'hBEEF); exp_fix[1] = 64'hBEEF;
        rd(1'b0, 4'd1, 2'd0, d, f); check("R9 permitted user write", d, 64'hBEEF);
        user_acc_en_i = 1'b0;
        // R8: unimplemented slots ignore writes
        wr(1'b0, 4'd5, 2'd1, 64'hAAAA);
        rd(1'b0, 4'd1, 2'd1, d, f); check("R8 fixed slot5 write ignored", d, exp_fix[1]);
        rd(1'b0, 4'd5, 2'd1, d, f); check("R8 fixed slot5 reads zero", d, 64'd0);
        wr(1'b1, 4'd5, 2'd1, 64'hBBBB);
        rd(1'b1, 4'd1, 2'd1, d, f); check("R8 aux slot5 write ignored", d, exp_aux[1]);

        // R10: write beats simultaneous increment
        wait_i = 1'b0; retire_cnt_i = 2'd3;
        wr(1'b0, 4'd2, 2'd1, 64'h1234_5678_9ABC_DEF0);
        wait_i = 1'b1; retire_cnt_i = 0;
        rd(1'b0, 4'd2, 2'd1, d, f); check("R10 load priority", d, 64'h1234_5678_9ABC_DEF0);

        // R11: wrap of the running core counter
        wait_i = 1'b0;
        wr(1'b0, 4'd0, 2'd1, '1);
        wait_i = 1'b1;
        rd(1'b0, 4'd0, 2'd1, d, f); check("R11 all ones loaded", d, '1);
        wait_i = 1'b0;
        edge_step();
        wait_i = 1'b1;
        rd(1'b0, 4'd0, 2'd1, d, f); check("R11 wrap to zero", d, 64'd0);
        rd(1'b1, 4'd3, 2'd1, d, f); check("R11 wrap aux", d, exp_aux[3]);

        // R12: read shows pre-edge value, then incremented value
        wait_i = 1'b0;
        acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_group_i = 1'b0; acc_idx_i = 4'd0; acc_priv_i = 2'd1;
        #1 v = rd_data_o;
        edge_step();
        check("R12 read before edge then +1", rd_data_o, v + 64'd1);
        acc_valid_i = 1'b0; wait_i = 1'b1;

        // R1: reset again from nonzero state
        apply_reset();
        for (int i = 0; i < 4; i++) begin rd(1'b0, 4'(i), 2'd1, d, f); check("R1 fixed cleared", d, 64'd0); end
        for (int i = 0; i < NA; i++) begin rd(1'b1, 4'(i), 2'd1, d, f); check("R1 aux cleared", d, 64'd0); end

        $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
        $finish;
    end
endmodule